// File: doc/BRIEF.md
# Constant-Fraction and Leading-Edge Pulse Discriminator

The block is the timing discriminator of one acquisition channel. It takes one signed,
baseline-referenced sample per clock and decides when a pulse has arrived. The sample
stream can be inverted so that pulses of either sign look positive. A moving-average
smoother of 2, 4, 8 or 16 taps can feed the trigger path instead of the raw samples.

Two ways of deciding are offered. In leading-edge mode the discriminator fires on the
first sample that rises above a programmed threshold. In constant-fraction mode it
builds a bipolar signal by subtracting a fixed fraction of the sample from a copy delayed
by a programmable number of samples. The threshold on that bipolar signal arms the
discriminator, and the next positive-to-non-positive zero crossing fires it. After a trigger, a guard
window of programmable length and an optional half-threshold hysteresis both suppress
further triggers. Besides the one-cycle trigger pulse, the block gives an armed flag and
an over-threshold output. That output is either a plain level or a non-retriggerable
pulse of programmable width.

Top module: `cfd_trigger`

## Requirements
- R1: When `invert_in` is 1, each sample is negated before any further processing, so a negative pulse triggers exactly as its positive mirror does with `invert_in` at 0.
- R2: The smoothed value is the arithmetic-shift average of the newest 2^`avg_log` samples (`avg_log` 0 to 4; 0 means no smoothing). The smoothed value drives the trigger path only when `avg_to_trig` is 1; otherwise the trigger path uses the plain sample.
- R3: With `cfd_sel` at 0, `trig` is a one-cycle pulse issued for a sample whose value is greater than `thresh` while the preceding sample was not. A value equal to `thresh` does not count. The pulse appears two clock edges after the edge that captured the sample.
- R4: With `cfd_sel` at 1, the bipolar value is the trigger-path sample from `cfd_dly` samples earlier, minus a fraction of the current one. `frac_code` 0, 1, 2 and 3 select 25 %, 50 %, 75 % and 100 %, computed as x>>2, x>>1, (x>>1)+(x>>2) and x.
- R5: With `cfd_sel` at 1, a bipolar value above `thresh` sets `armed`. An armed discriminator fires when the previous bipolar value is positive and the current one is zero or below. Firing clears `armed`. With `cfd_sel` at 0, `armed` stays 0.
- R6: After a trigger issued for sample j, samples j+1 to j+`guard_len` can neither fire nor arm. Sample j+`guard_len`+1 may fire again.
- R7: With `hyst_on` at 1, no trigger is allowed after a trigger until the discriminated value has fallen to `thresh`/2 or below.
- R8: With `pulse_len` at 0, `over_thr` follows, with the same two-edge latency as `trig`, whether the discriminated value (sample or bipolar) is above `thresh`.
- R9: With `pulse_len` nonzero, a rising threshold crossing that occurs while no pulse is running starts an `over_thr` pulse exactly `pulse_len` cycles long. Crossings during a running pulse neither extend nor restart it.
- R10: While `rst_n` is low, `trig`, `armed` and `over_thr` are 0, and all sample history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | DW | Signed baseline-referenced sample |
| invert_in | input | 1 | 1 = negate the input stream |
| avg_log | input | 3 | log2 of the smoothing window, 0 to 4 |
| avg_to_trig | input | 1 | 1 = trigger path uses smoothed samples |
| cfd_sel | input | 1 | 0 = leading edge, 1 = constant fraction |
| frac_code | input | 2 | Fraction: 0=25 %, 1=50 %, 2=75 %, 3=100 % |
| cfd_dly | input | log2(DLY_MAX) | Bipolar delay in samples |
| thresh | input | DW | Unsigned threshold |
| guard_len | input | CW | Retrigger guard length in samples |
| hyst_on | input | 1 | Enable half-threshold hysteresis |
| pulse_len | input | CW | Over-threshold pulse width, 0 = level output |
| trig | output | 1 | One-cycle trigger pulse |
| armed | output | 1 | Constant-fraction discriminator armed |
| over_thr | output | 1 | Over-threshold level or stretched pulse |

## Verification
The assertions assume that the configuration inputs stay constant while a pulse is being
processed. They also assume that `rst_n` clears the block before each new configuration takes effect, so that the guard,
hysteresis and armed state never carry across a change of mode. The stimulus keeps to this. Each
vector sets its configuration, then resets, then plays a short pulse train followed by zero samples. Sample
magnitudes stay well inside the signed range, so the 100 % fraction and the 16-tap sum
never approach the widened internal limits.

// File: rtl/cfd_trigger.sv
module cfd_trigger #(
  parameter int DW      = 16,
  parameter int DLY_MAX = 16,
  parameter int SLOG    = 4,
  parameter int CW      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [DW-1:0]       smp_in,
  input  logic                       invert_in,
  input  logic [2:0]                 avg_log,
  input  logic                       avg_to_trig,
  input  logic                       cfd_sel,
  input  logic [1:0]                 frac_code,
  input  logic [$clog2(DLY_MAX)-1:0] cfd_dly,
  input  logic [DW-1:0]              thresh,
  input  logic [CW-1:0]              guard_len,
  input  logic                       hyst_on,
  input  logic [CW-1:0]              pulse_len,
  output logic                       trig,
  output logic                       armed,
  output logic                       over_thr
);
  localparam int PW   = DW + 1;
  localparam int XW   = DW + 2;
  localparam int SW   = PW + SLOG;
  localparam int NTAP = 1 << SLOG;

  logic signed [PW-1:0] ext, pol, tsig, smooth, delayed, fr;
  logic signed [PW-1:0] hist [NTAP];
  logic signed [PW-1:0] dl [DLY_MAX];
  logic signed [SW-1:0] acc;
  logic signed [XW-1:0] bip, disc, prev_disc, thr_x, half_x;
  logic [2:0]           nlog;
  logic [CW-1:0]        guard_cnt, mono_cnt;
  logic                 hyst_blk, lin_r, above, prev_above, blocked, fire, arm_set;

  assign ext  = {smp_in[DW-1], smp_in};
  assign pol  = invert_in ? -ext : ext;
  assign nlog = (avg_log > 3'(SLOG)) ? 3'(SLOG) : avg_log;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NTAP; i++)
      if (i < (1 << nlog))
        acc = acc + {{SLOG{hist[i][PW-1]}}, hist[i]};
  end

  assign smooth  = PW'(acc >>> nlog);
  assign tsig    = avg_to_trig ? smooth : hist[0];
  assign delayed = (cfd_dly == '0) ? tsig : dl[cfd_dly - 1'b1];

  always_comb begin
    case (frac_code)
      2'd0:    fr = tsig >>> 2;
      2'd1:    fr = tsig >>> 1;
      2'd2:    fr = (tsig >>> 1) + (tsig >>> 2);
      default: fr = tsig;
    endcase
  end

  assign bip    = {delayed[PW-1], delayed} - {fr[PW-1], fr};
  assign disc   = cfd_sel ? bip : {tsig[PW-1], tsig};
  assign thr_x  = {2'b00, thresh};
  assign half_x = thr_x >>> 1;

  assign above      = disc > thr_x;
  assign prev_above = prev_disc > thr_x;
  assign blocked    = (guard_cnt != '0) || hyst_blk;
  assign arm_set    = cfd_sel && !blocked && above;
  assign fire       = !blocked && (cfd_sel ? (armed && prev_disc > 0 && disc <= 0)
                                           : (above && !prev_above));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAP; i++) hist[i] <= '0;
      for (int i = 0; i < DLY_MAX; i++) dl[i] <= '0;
    end else begin
      hist[0] <= pol;
      for (int i = 1; i < NTAP; i++) hist[i] <= hist[i-1];
      dl[0] <= tsig;
      for (int i = 1; i < DLY_MAX; i++) dl[i] <= dl[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig      <= 1'b0;
      armed     <= 1'b0;
      prev_disc <= '0;
      guard_cnt <= '0;
      hyst_blk  <= 1'b0;
      lin_r     <= 1'b0;
      mono_cnt  <= '0;
    end else begin
      trig      <= fire;
      prev_disc <= disc;
      lin_r     <= above;
      if (!cfd_sel || fire) armed <= 1'b0;
      else if (arm_set)     armed <= 1'b1;
      if (fire)                  guard_cnt <= guard_len;
      else if (guard_cnt != '0)  guard_cnt <= guard_cnt - 1'b1;
      if (fire && hyst_on)   hyst_blk <= 1'b1;
      else if (disc <= half_x) hyst_blk <= 1'b0;
      if (mono_cnt != '0)              mono_cnt <= mono_cnt - 1'b1;
      else if (above && !prev_above)   mono_cnt <= pulse_len;
    end
  end

  assign over_thr = (pulse_len == '0) ? lin_r : (mono_cnt != '0);

  AST_ONE_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) trig |=> !trig); // R3
  AST_LE_NO_ARM:      assert property (@(posedge clk) disable iff (!rst_n) !cfd_sel |=> !armed); // R5
  AST_FIRE_WHEN_ARMED: assert property (@(posedge clk) disable iff (!rst_n) (trig && $past(cfd_sel)) |-> $past(armed)); // R5
  AST_GUARD_BLOCK:    assert property (@(posedge clk) disable iff (!rst_n) (guard_cnt != '0) |=> !trig); // R6
  AST_HYST_BLOCK:     assert property (@(posedge clk) disable iff (!rst_n) hyst_blk |=> !trig); // R7
endmodule

// File: tb/tb_cfd_trigger.sv
module tb_cfd_trigger;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] smp_in = '0;
  logic invert_in = 0, avg_to_trig = 0, cfd_sel = 0, hyst_on = 0;
  logic [2:0] avg_log = '0;
  logic [1:0] frac_code = '0;
  logic [3:0] cfd_dly = '0;
  logic [15:0] thresh = 16'd50;
  logic [7:0] guard_len = '0, pulse_len = '0;
  logic trig, armed, over_thr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfd_trigger dut (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .invert_in(invert_in),
    .avg_log(avg_log), .avg_to_trig(avg_to_trig), .cfd_sel(cfd_sel),
    .frac_code(frac_code), .cfd_dly(cfd_dly), .thresh(thresh),
    .guard_len(guard_len), .hyst_on(hyst_on), .pulse_len(pulse_len),
    .trig(trig), .armed(armed), .over_thr(over_thr)
  );

  localparam int NV = 14;
  localparam logic signed [15:0] SMP [NV][10] = '{
    '{0, 0, 60, 80, 40, 70, 0, 50, 0, 0},
    '{0, -60, -20, -70, 0, 0, 0, 0, 0, 0},
    '{0, 60, 0, 60, 0, 60, 0, 0, 0, 0},
    '{0, 60, 30, 60, 20, 60, 0, 0, 0, 0},
    '{0, 0, 100, 100, 0, 0, 0, 0, 0, 0},
    '{0, 80, 80, 0, 0, 0, 0, 0, 0, 0},
    '{0, 40, 40, 40, 0, 0, 0, 0, 0, 0},
    '{0, 64, 64, 0, 0, 0, 0, 0, 0, 0},
    '{0, 80, 80, 0, 0, 0, 0, 0, 0, 0},
    '{0, 80, 0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 100, 100, 100, 100, 0, 0, 0, 0, 0},
    '{0, 60, 60, 60, 60, 60, 0, 70, 0, 0},
    '{0, 60, 0, 60, 0, 0, 0, 0, 0, 0},
    '{0, 60, 0, 0, 60, 0, 0, 0, 0, 0}
  };
  localparam int CFD  [NV] = '{0,0,0,0,1,1,1,1,0,0,0,0,0,0};
  localparam int FRAC [NV] = '{0,0,0,0,3,1,0,2,0,0,0,0,0,0};
  localparam int DLY  [NV] = '{0,0,0,0,2,1,3,1,0,0,0,0,0,0};
  localparam int THR  [NV] = '{50,50,50,50,50,50,30,10,50,50,50,50,50,50};
  localparam int NEG  [NV] = '{0,1,0,0,0,0,0,0,0,0,0,0,0,0};
  localparam int AVG  [NV] = '{0,0,0,0,0,0,0,0,1,2,2,0,0,0};
  localparam int TSM  [NV] = '{0,0,0,0,0,0,0,0,1,0,1,0,0,0};
  localparam int GRD  [NV] = '{0,0,3,0,0,0,0,0,0,0,0,0,0,3};
  localparam int HYS  [NV] = '{0,0,0,1,0,0,0,0,0,0,0,0,0,0};
  localparam int PLEN [NV] = '{0,0,0,0,0,0,0,0,0,0,0,3,4,0};
  localparam logic [15:0] ET [NV] = '{16'h0024,16'h000A,16'h0022,16'h0022,16'h0040,16'h0010,16'h0080,
                                      16'h0010,16'h0004,16'h0002,16'h0008,16'h0082,16'h000A,16'h0002};
  localparam logic [15:0] EA [NV] = '{16'h0000,16'h0000,16'h0000,16'h0000,16'h0030,16'h0008,16'h0070,
                                      16'h000C,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000};
  localparam logic [15:0] EO [NV] = '{16'h002C,16'h000A,16'h002A,16'h002A,16'h0030,16'h0008,16'h0070,
                                      16'h000C,16'h0004,16'h0002,16'h0038,16'h038E,16'h001E,16'h0012};

  function automatic string req_of(int v);
    case (v)
      0: return "R3";
      1: return "R1";
      2, 13: return "R6";
      3: return "R7";
      4: return "R5";
      5, 6, 7: return "R4";
      8, 9, 10: return "R2";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, string what, int v, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s vector %0d: actual %h expected %h", req, what, v, act, exp);
    end
  endtask

  task automatic run_vec(int v);
    logic [15:0] tm, am, om;
    tm = '0; am = '0; om = '0;
    @(negedge clk);
    rst_n = 1'b0; smp_in = '0;
    cfd_sel = 1'(CFD[v]); frac_code = 2'(FRAC[v]); cfd_dly = 4'(DLY[v]);
    thresh = 16'(THR[v]); invert_in = 1'(NEG[v]); avg_log = 3'(AVG[v]);
    avg_to_trig = 1'(TSM[v]); guard_len = 8'(GRD[v]); hyst_on = 1'(HYS[v]);
    pulse_len = 8'(PLEN[v]);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < 18; j++) begin
      if (j > 0) @(negedge clk);
      if (j >= 2) begin
        tm[j-2] = trig; am[j-2] = armed; om[j-2] = over_thr;
      end
      smp_in = (j < 10) ? SMP[v][j] : 16'sd0;
    end
    check(req_of(v), "trig", v, tm, ET[v]);
    check("R5", "armed", v, am, EA[v]);
    check((PLEN[v] == 0) ? "R8" : "R9", "over_thr", v, om, EO[v]);
  endtask

  initial begin
    // R10: outputs at reset
    repeat (3) @(negedge clk);
    check("R10", "reset outputs", 0, {13'd0, trig, armed, over_thr}, 16'h0000);
    for (int v = 0; v < NV; v++) run_vec(v);
    // R10: reset in the middle of a stretched pulse clears it
    @(negedge clk);
    pulse_len = 8'd6; cfd_sel = 0; thresh = 16'd50; smp_in = 16'sd90;
    repeat (3) @(negedge clk);
    check("R9", "pulse running", 1, {15'd0, over_thr}, 16'h0001);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "reset mid pulse", 1, {13'd0, trig, armed, over_thr}, 16'h0000);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule